// File: doc/BRIEF.md
# PAM-4 Bang-Bang Phase Decision Logic

This block is the digital timing-recovery core of a four-level serial receiver. It runs at one eighth of the symbol rate. Every cycle it takes a word of eight symbols from three threshold slices. Each slice supplies one data-sample bit and one edge-sample bit per symbol position. The slices sit between adjacent amplitude levels (low: between 0 and 1, middle: between 1 and 2, high: between 2 and 3), so the three data bits of a symbol form a thermometer code. The symbol level is the number of slice bits that are set.

For each symbol position the block looks at the transition from the previous symbol into the current one, and at the edge sample taken between them. Only transitions whose crossing falls midway between data samples are trusted: the three single-step moves and the full-swing 0-3 move. From each trusted transition it derives an early flag or a late flag. The flags are reduced in two stages of majority voting: first within groups of positions, then across the groups. The result is one early, late or no-vote indication per word.

A signed accumulator integrates these votes. When it reaches a programmable magnitude it issues a one-cycle advance or retard pulse to the phase rotator controller and clears.

Top module: `cdr_vote_logic`

## Requirements
- R1: After a synchronous active-low reset, both step outputs are 0, the accumulator is 0, and the carried previous symbol is level 0. A reset in the middle of accumulation discards the partial count.
- R2: For a transition between adjacent levels, in either direction, only the edge bit of the slice whose threshold lies between the two levels is used. If it equals that slice's bit in the previous symbol, the position is flagged late. If it equals the bit in the current symbol, the position is flagged early.
- R3: A transition between levels 0 and 3, in either direction, is judged by the middle slice's edge bit, using the same early and late rule as R2.
- R4: Transitions 0-2 and 1-3 (either direction), and positions where the level does not change, raise no flag whatever the edge bits are.
- R5: The transition at position 0 is taken from the last symbol (position 7) of the previous word to symbol 0 of the current word.
- R6: In each group of four adjacent positions (0-3, 4-7), the group votes early only if its early flags outnumber its late flags, and late only if its late flags outnumber its early flags. Otherwise it casts no vote.
- R7: The word decision is early only if more groups vote early than late, and late only if more groups vote late than early. Otherwise there is no decision.
- R8: Each early decision adds 1 to the accumulator. When the sum reaches +threshold, `phase_up` pulses for one cycle and the accumulator clears.
- R9: Each late decision subtracts 1. When the sum reaches -threshold, `phase_dn` pulses for one cycle and the accumulator clears. Early and late decisions cancel.
- R10: A threshold input of 0 behaves as a threshold of 1.
- R11: `phase_up` and `phase_dn` are never both 1.
- R12: A word applied before clock edge k affects the step outputs from edge k+1 onward. A step pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, one eighth of symbol rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_lo_d | input | NSYM | Low-slice data samples, bit i = symbol i |
| smp_mid_d | input | NSYM | Middle-slice data samples |
| smp_hi_d | input | NSYM | High-slice data samples |
| smp_lo_e | input | NSYM | Low-slice edge samples, bit i = crossing before symbol i |
| smp_mid_e | input | NSYM | Middle-slice edge samples |
| smp_hi_e | input | NSYM | High-slice edge samples |
| step_thresh | input | ACC_W-1 | Accumulator magnitude that triggers a step (0 acts as 1) |
| phase_up | output | 1 | One-cycle request to advance the sampling phase |
| phase_dn | output | 1 | One-cycle request to retard the sampling phase |

## Verification
The transition across the word boundary is evaluated in the same cycle that the carry register replaces its stored last symbol with the new word's last symbol. A wrong ordering would judge position 0 against the wrong level. Words are provoked in which only position 0 holds a usable transition, and one word where the correct carried level makes position 0 unusable while a stale level of 0 would make it a 0-3 move. Each case is judged by the direction, or absence, of the step pulse. The accumulator's clear-on-step also coincides with a new vote arriving, which is judged by the counts of further votes needed before the next pulse.

// File: rtl/cdr_vote_pkg.sv
// Package: shared vote type and the majority rule used at both voting levels.
// Assumes counts are small non-negative integers.
package cdr_vote_pkg;

    typedef enum logic [1:0] {
        VOTE_NONE  = 2'b00,
        VOTE_EARLY = 2'b01,
        VOTE_LATE  = 2'b10
    } vote_t;

    // Strict majority: a tie between early and late yields no vote.
    function automatic vote_t majority(input int unsigned n_early, input int unsigned n_late);
        if (n_early > n_late)
            return VOTE_EARLY;
        else if (n_late > n_early)
            return VOTE_LATE;
        else
            return VOTE_NONE;
    endfunction

    // Amplitude level of a thermometer-coded symbol {hi, mid, lo}.
    function automatic logic [1:0] level_of(input logic [2:0] sl);
        return 2'({1'b0, sl[0]} + {1'b0, sl[1]} + {1'b0, sl[2]});
    endfunction

endpackage

// File: rtl/cdr_trans_detect.sv
// Module: per-position transition classifier.
// For every symbol position it finds the transition from the preceding
// symbol and, if that transition crosses at mid-symbol (single step or 0-3),
// compares the relevant slice's edge bit with the data bits on either side.
// Assumes slice data bits are thermometer coded. Purely combinational.
module cdr_trans_detect
    import cdr_vote_pkg::*;
#(
    parameter int NSYM = 8
) (
    input  logic [NSYM-1:0] d_lo,
    input  logic [NSYM-1:0] d_mid,
    input  logic [NSYM-1:0] d_hi,
    input  logic [NSYM-1:0] e_lo,
    input  logic [NSYM-1:0] e_mid,
    input  logic [NSYM-1:0] e_hi,
    input  logic [2:0]      prev_sl,
    output logic [NSYM-1:0] early,
    output logic [NSYM-1:0] late
);

    for (genvar g = 0; g < NSYM; g++) begin : g_pos
        logic [2:0] sa;
        logic [2:0] sb;
        logic [2:0] ev;
        logic [1:0] la;
        logic [1:0] lb;
        logic [1:0] sel;
        logic       usable;

        if (g == 0) begin : g_first
            assign sa = prev_sl;
        end else begin : g_rest
            assign sa = {d_hi[g-1], d_mid[g-1], d_lo[g-1]};
        end
        assign sb = {d_hi[g], d_mid[g], d_lo[g]};
        assign ev = {e_hi[g], e_mid[g], e_lo[g]};

        // Pick the judging slice and decide whether the transition is usable.
        always_comb begin
            la     = level_of(sa);
            lb     = level_of(sb);
            sel    = 2'd1;
            usable = 1'b0;
            if ({1'b0, la} == {1'b0, lb} + 3'd1) begin
                sel    = lb;
                usable = 1'b1;
            end else if ({1'b0, lb} == {1'b0, la} + 3'd1) begin
                sel    = la;
                usable = 1'b1;
            end else if ((la == 2'd0 && lb == 2'd3) || (la == 2'd3 && lb == 2'd0)) begin
                sel    = 2'd1;
                usable = 1'b1;
            end
        end

        // Edge matching the new symbol means the clock is early, else late.
        always_comb begin
            early[g] = usable && (ev[sel] == sb[sel]);
            late[g]  = usable && (ev[sel] == sa[sel]);
        end
    end

endmodule

// File: rtl/cdr_maj_tree.sv
// Module: two-level majority reduction of the early/late flag vectors.
// Level one votes inside groups of GROUP adjacent positions, level two votes
// across the groups. Ties give no vote at either level.
// Assumes NSYM is a multiple of GROUP. Purely combinational.
module cdr_maj_tree
    import cdr_vote_pkg::*;
#(
    parameter int NSYM  = 8,
    parameter int GROUP = 4
) (
    input  logic [NSYM-1:0] early,
    input  logic [NSYM-1:0] late,
    output vote_t           vote
);

    localparam int NGRP = NSYM / GROUP;

    logic [NGRP-1:0] grp_early;
    logic [NGRP-1:0] grp_late;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        vote_t gv;

        // Count flags inside one group and apply the strict majority rule.
        always_comb begin
            int unsigned ne;
            int unsigned nl;
            ne = 0;
            nl = 0;
            for (int k = 0; k < GROUP; k++) begin
                ne += int'(early[g*GROUP+k]);
                nl += int'(late[g*GROUP+k]);
            end
            gv = majority(ne, nl);
        end

        assign grp_early[g] = (gv == VOTE_EARLY);
        assign grp_late[g]  = (gv == VOTE_LATE);
    end

    // Second level: majority across the group votes.
    always_comb begin
        int unsigned ne;
        int unsigned nl;
        ne = 0;
        nl = 0;
        for (int k = 0; k < NGRP; k++) begin
            ne += int'(grp_early[k]);
            nl += int'(grp_late[k]);
        end
        vote = majority(ne, nl);
    end

endmodule

// File: rtl/cdr_loop_filter.sv
// Module: signed accumulating loop filter.
// Integrates +1 per early vote and -1 per late vote. On reaching +/-threshold
// it emits a one-cycle step and clears. A threshold of 0 acts as 1.
// Assumes threshold is held steady while accumulation is in progress.
module cdr_loop_filter
    import cdr_vote_pkg::*;
#(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vote_t            vote,
    input  logic [ACC_W-2:0] thresh,
    output logic             step_up,
    output logic             step_dn
);

    localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_nx;
    logic signed [ACC_W-1:0] thr_eff;
    logic signed [ACC_W-1:0] delta;
    logic                    hit_up;
    logic                    hit_dn;

    // Effective threshold and next accumulator value.
    always_comb begin
        thr_eff = (thresh == '0) ? ONE : $signed({1'b0, thresh});
        case (vote)
            VOTE_EARLY: delta = ONE;
            VOTE_LATE:  delta = -ONE;
            default:    delta = '0;
        endcase
        acc_nx = acc_q + delta;
        hit_up = (acc_nx >= thr_eff);
        hit_dn = (acc_nx <= -thr_eff);
    end

    // Accumulator update with clear on step, and registered step pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            step_up <= 1'b0;
            step_dn <= 1'b0;
        end else begin
            step_up <= hit_up;
            step_dn <= hit_dn;
            acc_q   <= (hit_up || hit_dn) ? '0 : acc_nx;
        end
    end

    assert_dir_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    assert_up_from_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |-> $past(vote == VOTE_EARLY));

    assert_dn_from_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn |-> $past(vote == VOTE_LATE));

endmodule

// File: rtl/cdr_vote_logic.sv
// Module: top of the bang-bang phase decision logic.
// Stage 1 classifies transitions per position and registers the flags,
// together with the last symbol of the word for the next word's position 0.
// Stage 2 votes on the registered flags and updates the loop filter.
// Assumes thermometer-coded slice data; NSYM a multiple of GROUP.
module cdr_vote_logic
    import cdr_vote_pkg::*;
#(
    parameter int NSYM  = 8,
    parameter int GROUP = 4,
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSYM-1:0]  smp_lo_d,
    input  logic [NSYM-1:0]  smp_mid_d,
    input  logic [NSYM-1:0]  smp_hi_d,
    input  logic [NSYM-1:0]  smp_lo_e,
    input  logic [NSYM-1:0]  smp_mid_e,
    input  logic [NSYM-1:0]  smp_hi_e,
    input  logic [ACC_W-2:0] step_thresh,
    output logic             phase_up,
    output logic             phase_dn
);

    logic [NSYM-1:0] early_c;
    logic [NSYM-1:0] late_c;
    logic [NSYM-1:0] early_q;
    logic [NSYM-1:0] late_q;
    logic [2:0]      prev_q;
    vote_t           vote;

    cdr_trans_detect #(.NSYM(NSYM)) u_detect (
        .d_lo    (smp_lo_d),
        .d_mid   (smp_mid_d),
        .d_hi    (smp_hi_d),
        .e_lo    (smp_lo_e),
        .e_mid   (smp_mid_e),
        .e_hi    (smp_hi_e),
        .prev_sl (prev_q),
        .early   (early_c),
        .late    (late_c)
    );

    // Register the flags and carry the word's last symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_q <= '0;
            late_q  <= '0;
            prev_q  <= '0;
        end else begin
            early_q <= early_c;
            late_q  <= late_c;
            prev_q  <= {smp_hi_d[NSYM-1], smp_mid_d[NSYM-1], smp_lo_d[NSYM-1]};
        end
    end

    cdr_maj_tree #(.NSYM(NSYM), .GROUP(GROUP)) u_vote (
        .early (early_q),
        .late  (late_q),
        .vote  (vote)
    );

    cdr_loop_filter #(.ACC_W(ACC_W)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .vote    (vote),
        .thresh  (step_thresh),
        .step_up (phase_up),
        .step_dn (phase_dn)
    );

    assert_flags_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (early_q & late_q) == '0);

    assert_early_vote_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vote == VOTE_EARLY) |-> (early_q != '0));

    assert_late_vote_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vote == VOTE_LATE) |-> (late_q != '0));

endmodule

// File: tb/sim_cdr_vote_logic.sv
`timescale 1ns/1ps
module sim_cdr_vote_logic;

    localparam int NSYM  = 8;
    localparam int ACC_W = 8;
    localparam int NVEC  = 12;

    // Table: symbol levels (2 bits per position, position 0 lowest),
    // intent per position (01 early, 10 late), filler edge bit, expected {up,dn}.
    localparam logic [15:0] T_LV [NVEC] = '{
        16'h0000, 16'h4444, 16'h6666, 16'hEEEE, 16'hCCCC, 16'hDDDD,
        16'h2222, 16'h5555, 16'hFFFF, 16'hAAAA, 16'h9999, 16'h9999};
    localparam logic [15:0] T_IN [NVEC] = '{
        16'h0000, 16'h5554, 16'hAAAA, 16'h95A5, 16'hAAAA, 16'h0000,
        16'h0001, 16'h0002, 16'h0000, 16'h0001, 16'h6A95, 16'h99AA};
    localparam logic [2:0]  T_FX [NVEC] = '{
        3'b100, 3'b110, 3'b101, 3'b110, 3'b101, 3'b100,
        3'b010, 3'b101, 3'b100, 3'b010, 3'b000, 3'b001};
    localparam string T_RQ [NVEC] = '{
        "R4 steady", "R2 rising", "R2 falling", "R6 tie", "R3 full swing", "R4 1-3",
        "R4 0-2", "R5 boundary", "R5 stale", "R5 carry", "R7 tie", "R7 late"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSYM-1:0]  d_lo = '0, d_mid = '0, d_hi = '0;
    logic [NSYM-1:0]  e_lo = '0, e_mid = '0, e_hi = '0;
    logic [ACC_W-2:0] thr = 7'd1;
    logic             phase_up;
    logic             phase_dn;

    int n_run  = 0;
    int n_fail = 0;
    int n_both = 0;
    logic [1:0] tb_prev = 2'd0;
    logic [1:0] obs;
    bit done = 1'b0;

    cdr_vote_logic #(.NSYM(NSYM), .GROUP(4), .ACC_W(ACC_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_lo_d    (d_lo),
        .smp_mid_d   (d_mid),
        .smp_hi_d    (d_hi),
        .smp_lo_e    (e_lo),
        .smp_mid_e   (e_mid),
        .smp_hi_e    (e_hi),
        .step_thresh (thr),
        .phase_up    (phase_up),
        .phase_dn    (phase_dn)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {up,dn} actual %b expected %b", req, act, exp);
        end
    endtask

    // Edge bits built from the early/late rules for the judging slice.
    function automatic logic [23:0] mk_edges(input logic [1:0] prev, input logic [15:0] lv,
                                             input logic [15:0] it, input logic fill);
        logic [7:0] el, em, eh;
        el = {8{fill}};
        em = {8{fill}};
        eh = {8{fill}};
        for (int i = 0; i < 8; i++) begin
            int a, b, s;
            logic v;
            if (i == 0) a = int'(prev);
            else        a = int'(lv[2*(i-1) +: 2]);
            b = int'(lv[2*i +: 2]);
            s = -1;
            if (a == b + 1)                                s = b;
            else if (b == a + 1)                           s = a;
            else if ((a == 0 && b == 3) || (a == 3 && b == 0)) s = 1;
            if (s >= 0 && it[2*i +: 2] != 2'b00) begin
                v = (it[2*i +: 2] == 2'b01) ? (b > s) : (a > s);
                case (s)
                    0:       el[i] = v;
                    1:       em[i] = v;
                    default: eh[i] = v;
                endcase
            end
        end
        return {eh, em, el};
    endfunction

    task automatic drive(input logic [15:0] lv, input logic [23:0] ed);
        for (int i = 0; i < 8; i++) begin
            d_lo[i]  = (lv[2*i +: 2] > 2'd0);
            d_mid[i] = (lv[2*i +: 2] > 2'd1);
            d_hi[i]  = (lv[2*i +: 2] > 2'd2);
        end
        {e_hi, e_mid, e_lo} = ed;
    endtask

    // Apply one word, then a steady word, and sample the step two edges later.
    task automatic send(input logic [15:0] lv, input logic [15:0] it, input logic fill);
        logic [1:0] last;
        @(negedge clk);
        drive(lv, mk_edges(tb_prev, lv, it, fill));
        last = lv[15:14];
        tb_prev = last;
        @(negedge clk);
        drive({8{last}}, 24'h0);
        @(negedge clk);
        obs = {phase_up, phase_dn};
        if (obs == 2'b11) n_both++;
    endtask

    // One word carrying a single usable transition at position 0.
    task automatic send_dir(input bit is_late);
        logic [1:0] q;
        q = (tb_prev == 2'd0) ? 2'd1 : tb_prev - 2'd1;
        send({8{q}}, is_late ? 16'h0002 : 16'h0001, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive(16'h0000, 24'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tb_prev = 2'd0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {phase_up, phase_dn}, 2'b00);

        // Table walk at threshold 1: each word's decision shows directly
        thr = 7'd1;
        for (int v = 0; v < NVEC; v++) begin
            send(T_LV[v], T_IN[v], T_FX[v][2]);
            chk(T_RQ[v], obs, T_FX[v][1:0]);
        end

        // R12: latency and one-cycle pulse
        @(negedge clk);
        drive(16'h5555, mk_edges(tb_prev, 16'h5555, 16'h0001, 1'b0));
        tb_prev = 2'd1;
        @(negedge clk);
        chk("R12 no output after one edge", {phase_up, phase_dn}, 2'b00);
        drive(16'h5555, 24'h0);
        @(negedge clk);
        chk("R12 pulse after two edges", {phase_up, phase_dn}, 2'b10);
        @(negedge clk);
        chk("R12 pulse ends", {phase_up, phase_dn}, 2'b00);

        // R8: threshold 3, step on third early, then clear
        thr = 7'd3;
        send_dir(0); chk("R8 count 1", obs, 2'b00);
        send_dir(0); chk("R8 count 2", obs, 2'b00);
        send_dir(0); chk("R8 reach +3", obs, 2'b10);
        send_dir(0); chk("R8 cleared 1", obs, 2'b00);
        send_dir(0); chk("R8 cleared 2", obs, 2'b00);
        send_dir(0); chk("R8 reach +3 again", obs, 2'b10);

        // R9: threshold 2, step on second late
        thr = 7'd2;
        send_dir(1); chk("R9 count -1", obs, 2'b00);
        send_dir(1); chk("R9 reach -2", obs, 2'b01);

        // R9: opposite votes cancel
        send_dir(0); chk("R9 mix +1", obs, 2'b00);
        send_dir(1); chk("R9 mix 0", obs, 2'b00);
        send_dir(0); chk("R9 mix +1 again", obs, 2'b00);
        send_dir(0); chk("R9 mix +2", obs, 2'b10);

        // R10: threshold 0 acts as 1
        thr = 7'd0;
        send_dir(0); chk("R10 zero thresh up", obs, 2'b10);
        send_dir(1); chk("R10 zero thresh dn", obs, 2'b01);

        // R1: reset discards partial accumulation
        thr = 7'd3;
        send_dir(0); chk("R1 pre-reset 1", obs, 2'b00);
        send_dir(0); chk("R1 pre-reset 2", obs, 2'b00);
        do_reset();
        chk("R1 after reset", {phase_up, phase_dn}, 2'b00);
        send_dir(0); chk("R1 restart 1", obs, 2'b00);
        send_dir(0); chk("R1 restart 2", obs, 2'b00);
        send_dir(0); chk("R1 restart 3", obs, 2'b10);

        // R11: never both directions in any sampled cycle
        chk("R11 exclusive", (n_both == 0) ? 2'b00 : 2'b11, 2'b00);

        done = 1'b1;
        finish_run();
    end

endmodule